// File: doc/BRIEF.md
# Serial Controller Register Bank

This block is the host-facing side of a serial I/O controller. It holds a bank of 32-bit control and status words, a transmit queue and a receive queue, and a level interrupt. The host writes characters into a transmit data word, and a downstream serializer drains them through a valid/ready byte stream. Characters from the line side arrive on a valid-only byte stream. They are queued and then read by the host from a receive data word.

Every access names a word by its word address (byte offset divided by four) and carries four byte enables. Enable `be[0]` selects the most significant lane, bits 31:24, and `be[3]` selects bits 7:0. Writable words keep only their masked bits. Interrupt status flags are raised by queue occupancy and can be lowered only by writing zeros. A FIFO control write can flush either queue. Reset is synchronous and active low.

Word map (word address : content): 0 line control, 1 line status, 2 interrupt enable, 3 interrupt status, 4 FIFO control, 5 rate control, 8 transmit data, 12 receive data.

Top module: `sio_regbank`

## Requirements
- R1: A clock edge with `rst_n` low sets line control to 0x40000000 and rate control to 0x03FF0000. It clears every other word, both queues and `rdata`. `tx_valid` and `irq` are low on the cycle after that edge.
- R2: A read with `rd_en` returns its word in `rdata` one cycle later, with disabled lanes zero, and `rdata` is zero after a cycle without a read. The store masks are: line control 0xE17F0000, interrupt enable 0x000F0000, FIFO control 0x001F0000, rate control 0x03FF0000. Writes to line status have no effect.
- R3: A write changes only the enabled byte lanes of a writable word. The other lanes keep their value.
- R4: A write to word 8 with `be[0]` set appends `wdata[31:24]` to the 16-entry transmit queue. The write is dropped when the queue is full. Writes with `be[0]` clear do nothing, and reads of word 8 return zero.
- R5: `tx_valid` is high while the transmit queue holds data, and `tx_data` shows the oldest character. A cycle with `tx_valid` and `tx_ready` both high removes that character.
- R6: A cycle with `rx_valid` high appends `rx_data` to the 16-entry receive queue. If the queue is full, the character is dropped and line status bit 16 is set. That bit stays set until reset.
- R7: A read of word 12 with `be[0]` set removes the oldest received character and returns it in `rdata[31:24]`. An empty queue or a cleared `be[0]` returns zero and leaves the queue as it was.
- R8: Interrupt status bit 16 is set on any cycle that begins with the receive queue non-empty. Bit 17 is set on any cycle that begins with the transmit queue empty. Both bits stay set until cleared.
- R9: A write to interrupt status ANDs each enabled lane with `wdata`, under mask 0x00070000, so it can only clear bits. The set conditions of R8 still apply in that same cycle.
- R10: `irq` is high exactly when some bit is set in both interrupt status and interrupt enable. In interrupt enable, bit 16 enables receive, bit 17 transmit and bit 18 error. Bit 19 is stored only.
- R11: A FIFO control write whose resulting value has bit 16 set flushes the transmit queue if bit 18 is set and the receive queue if bit 17 is set. A flush overrides any stream transfer in the same cycle. Without bit 16, no queue is flushed.
- R12: Reads of word addresses outside the map return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| waddr | input | ADDR_W (6) | Word address (byte offset / 4) |
| be | input | 4 | Byte enables; be[0] is bits 31:24 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after rd_en |
| tx_data | output | 8 | Oldest transmit character |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_ready | input | 1 | Downstream takes tx_data |
| rx_data | input | 8 | Incoming character |
| rx_valid | input | 1 | rx_data is present this cycle |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach are the two full queues: a dropped transmit write and a receive overrun both need sixteen stored entries first. The bench holds `tx_ready` low while it writes eighteen transmit characters. It also sends eighteen receive characters with no reads in between, and then reads line status to see the overrun flag. The flag-versus-clear race is reached by writing zeros to interrupt status while the transmit queue is still empty, and again after a character is queued. A flush is issued while characters are still being offered on both streams in the same cycle.

// File: rtl/sio_pkg.sv
// Shared constants for the serial controller register bank.
// Assumes a 32-bit data bus with four byte enables, be[0] = bits 31:24.
package sio_pkg;

    // word indexes (byte offset / 4)
    localparam int IDX_LCTL  = 0;
    localparam int IDX_LSTAT = 1;
    localparam int IDX_IEN   = 2;
    localparam int IDX_ISTAT = 3;
    localparam int IDX_FCTL  = 4;
    localparam int IDX_RATE  = 5;
    localparam int IDX_TXD   = 8;
    localparam int IDX_RXD   = 12;

    // store masks
    localparam logic [31:0] MASK_LCTL  = 32'hE17F_0000;
    localparam logic [31:0] MASK_IEN   = 32'h000F_0000;
    localparam logic [31:0] MASK_ISTAT = 32'h0007_0000;
    localparam logic [31:0] MASK_FCTL  = 32'h001F_0000;
    localparam logic [31:0] MASK_RATE  = 32'h03FF_0000;

    // reset images
    localparam logic [31:0] RST_LCTL = 32'h4000_0000;
    localparam logic [31:0] RST_RATE = 32'h03FF_0000;

    // bit positions that other logic decodes
    localparam int BIT_RX_FLAG  = 16;
    localparam int BIT_TX_FLAG  = 17;
    localparam int BIT_OVERRUN  = 16;
    localparam int BIT_FL_EN    = 16;
    localparam int BIT_FL_RX    = 17;
    localparam int BIT_FL_TX    = 18;

    // expand byte enables into a bit mask, lane 0 is most significant
    function automatic logic [31:0] lane_bits(input logic [3:0] be);
        return {{8{be[0]}}, {8{be[1]}}, {8{be[2]}}, {8{be[3]}}};
    endfunction

endpackage

// File: rtl/sio_fifo.sv
// Character queue with drop-on-full push, ignore-on-empty pop and flush.
// Assumes push and pop decisions use the occupancy at the start of the cycle;
// flush wins over any push or pop in the same cycle.
module sio_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic         flush,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rptr;
    logic [PW-1:0] wptr;
    logic [CW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rptr];

    // storage write on accepted push
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= din;
        end
    end

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rptr <= '0;
            wptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/sio_csr_word.sv
// One 32-bit writable word with byte-lane writes, a store mask and a reset image.
// CLEAR_ONLY selects AND-with-written-data semantics; set_bits are ORed in every cycle.
module sio_csr_word
    import sio_pkg::*;
#(
    parameter logic [31:0] MASK       = 32'hFFFF_FFFF,
    parameter logic [31:0] RST_VAL    = 32'h0,
    parameter bit          CLEAR_ONLY = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic [31:0] set_bits,
    output logic [31:0] q
);
    logic [31:0] lanes;
    logic [31:0] written;
    logic [31:0] nxt;

    assign lanes = lane_bits(be);

    generate
        if (CLEAR_ONLY) begin : g_clear
            assign written = q & (wdata | ~lanes);
        end else begin : g_load
            assign written = (q & ~lanes) | (wdata & lanes);
        end
    endgenerate

    // next value: optional write, then hardware set bits, then mask
    always_comb begin
        nxt = wr ? written : q;
        nxt = (nxt | set_bits) & MASK;
    end

    // register with synchronous reset image
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= nxt;
    end

endmodule

// File: rtl/sio_regbank.sv
// Host register bank of a serial controller: decode, control words, two
// character queues, occupancy-driven interrupt flags and a level interrupt.
// Assumes one access per cycle (wr_en and rd_en not both set by the host).
module sio_regbank
    import sio_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int QDEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              irq
);
    logic [31:0] lctl_q, ien_q, istat_q, fctl_q, rate_q, lstat_v;
    logic        sel_lctl, sel_ien, sel_istat, sel_fctl, sel_rate, sel_txd, sel_rxd;
    logic        tx_empty, tx_full, rx_empty, rx_full;
    logic [7:0]  rx_head;
    logic        ovr_q;
    logic        fl_en, fl_tx, fl_rx;
    logic [31:0] istat_set;
    logic [31:0] rd_word;

    // word decode
    assign sel_lctl  = (waddr == ADDR_W'(IDX_LCTL));
    assign sel_ien   = (waddr == ADDR_W'(IDX_IEN));
    assign sel_istat = (waddr == ADDR_W'(IDX_ISTAT));
    assign sel_fctl  = (waddr == ADDR_W'(IDX_FCTL));
    assign sel_rate  = (waddr == ADDR_W'(IDX_RATE));
    assign sel_txd   = (waddr == ADDR_W'(IDX_TXD));
    assign sel_rxd   = (waddr == ADDR_W'(IDX_RXD));

    // control words
    sio_csr_word #(.MASK(MASK_LCTL), .RST_VAL(RST_LCTL), .CLEAR_ONLY(1'b0)) u_lctl (
        .clk(clk), .rst_n(rst_n), .wr(wr_en & sel_lctl), .be(be), .wdata(wdata),
        .set_bits(32'h0), .q(lctl_q));

    sio_csr_word #(.MASK(MASK_IEN), .RST_VAL(32'h0), .CLEAR_ONLY(1'b0)) u_ien (
        .clk(clk), .rst_n(rst_n), .wr(wr_en & sel_ien), .be(be), .wdata(wdata),
        .set_bits(32'h0), .q(ien_q));

    sio_csr_word #(.MASK(MASK_FCTL), .RST_VAL(32'h0), .CLEAR_ONLY(1'b0)) u_fctl (
        .clk(clk), .rst_n(rst_n), .wr(wr_en & sel_fctl), .be(be), .wdata(wdata),
        .set_bits(32'h0), .q(fctl_q));

    sio_csr_word #(.MASK(MASK_RATE), .RST_VAL(RST_RATE), .CLEAR_ONLY(1'b0)) u_rate (
        .clk(clk), .rst_n(rst_n), .wr(wr_en & sel_rate), .be(be), .wdata(wdata),
        .set_bits(32'h0), .q(rate_q));

    // status flags follow queue occupancy at the start of the cycle
    always_comb begin
        istat_set              = '0;
        istat_set[BIT_RX_FLAG] = ~rx_empty;
        istat_set[BIT_TX_FLAG] = tx_empty;
    end

    sio_csr_word #(.MASK(MASK_ISTAT), .RST_VAL(32'h0), .CLEAR_ONLY(1'b1)) u_istat (
        .clk(clk), .rst_n(rst_n), .wr(wr_en & sel_istat), .be(be), .wdata(wdata),
        .set_bits(istat_set), .q(istat_q));

    // flush decode: the flush bits all sit in lane 1
    always_comb begin
        fl_en = 1'b0;
        fl_tx = 1'b0;
        fl_rx = 1'b0;
        if (wr_en && sel_fctl) begin
            fl_en = be[1] ? wdata[BIT_FL_EN] : fctl_q[BIT_FL_EN];
            fl_tx = fl_en & (be[1] ? wdata[BIT_FL_TX] : fctl_q[BIT_FL_TX]);
            fl_rx = fl_en & (be[1] ? wdata[BIT_FL_RX] : fctl_q[BIT_FL_RX]);
        end
    end

    // transmit queue: host pushes, downstream drains
    sio_fifo #(.W(8), .DEPTH(QDEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(wr_en & sel_txd & be[0]),
        .pop(tx_valid & tx_ready),
        .flush(fl_tx),
        .din(wdata[31:24]),
        .dout(tx_data),
        .empty(tx_empty),
        .full(tx_full));

    assign tx_valid = ~tx_empty;

    // receive queue: line side pushes, host pops through word 12 lane 0
    sio_fifo #(.W(8), .DEPTH(QDEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_valid),
        .pop(rd_en & sel_rxd & be[0]),
        .flush(fl_rx),
        .din(rx_data),
        .dout(rx_head),
        .empty(rx_empty),
        .full(rx_full));

    // sticky overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_q | (rx_valid & rx_full);
    end

    always_comb begin
        lstat_v              = '0;
        lstat_v[BIT_OVERRUN] = ovr_q;
    end

    // read multiplexer
    always_comb begin
        case (waddr)
            ADDR_W'(IDX_LCTL):  rd_word = lctl_q;
            ADDR_W'(IDX_LSTAT): rd_word = lstat_v;
            ADDR_W'(IDX_IEN):   rd_word = ien_q;
            ADDR_W'(IDX_ISTAT): rd_word = istat_q;
            ADDR_W'(IDX_FCTL):  rd_word = fctl_q;
            ADDR_W'(IDX_RATE):  rd_word = rate_q;
            ADDR_W'(IDX_RXD):   rd_word = (be[0] && !rx_empty) ? {rx_head, 24'h0} : 32'h0;
            default:            rd_word = 32'h0;
        endcase
    end

    // registered read data, zero when no read
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_word & lane_bits(be);
        else            rdata <= '0;
    end

    // level interrupt
    assign irq = |(istat_q & ien_q);

    // unused-bit sink for tx_full (decisions are local to the queue)
    logic unused_ok;
    assign unused_ok = tx_full;

endmodule

// File: rtl/sio_regbank_chk.sv
// Property checker for sio_regbank, bound into every instance.
// Assumes the default word map; observes ports and the overrun flag.
module sio_regbank_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] waddr,
    input logic [3:0]        be,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              irq,
    input logic              ovr
);
    logic mapped;
    logic fctl_wr;

    assign mapped = (waddr <= ADDR_W'(5)) || (waddr == ADDR_W'(8)) || (waddr == ADDR_W'(12));
    assign fctl_wr = wr_en && (waddr == ADDR_W'(4));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !irq && rdata == 32'h0));

    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !fctl_wr) |=> (tx_valid && $stable(tx_data)));

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> ovr);

    assert_rxd_low_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && waddr == ADDR_W'(12)) |=> (rdata[23:0] == 24'h0));

    assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && waddr == ADDR_W'(2) && be == 4'hF && wdata[19:16] == 4'h0) |=> !irq);

    assert_tx_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fctl_wr && be[1] && wdata[16] && wdata[18]) |=> !tx_valid);

    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rdata == 32'h0));

endmodule

bind sio_regbank sio_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .waddr(waddr),
    .be(be), .wdata(wdata), .rdata(rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq), .ovr(ovr_q));

// File: tb/sim_sio_regbank.sv
// Bench for sio_regbank: behavioural queue model compared on every falling edge.
module sim_sio_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  waddr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        irq;

    always #5 clk = ~clk;

    sio_regbank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .waddr(waddr),
        .be(be), .wdata(wdata), .rdata(rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .irq(irq));

    // reference state
    logic [7:0]  txq[$];
    logic [7:0]  rxq[$];
    logic [31:0] m_lctl, m_lstat, m_ien, m_istat, m_fctl, m_rate, e_rdata;
    int          vectors = 0;
    int          miscompares = 0;
    int          cycles = 0;
    bit          started = 0;
    bit          done = 0;
    string       cur_req = "R1";

    function automatic logic [31:0] lm(input logic [3:0] b);
        return {{8{b[0]}}, {8{b[1]}}, {8{b[2]}}, {8{b[3]}}};
    endfunction

    function automatic logic [31:0] ld(input logic [31:0] o, input logic [31:0] m);
        return ((o & ~lm(be)) | (wdata & lm(be))) & m;
    endfunction

    // reference model step
    always @(posedge clk) begin
        int tc, rc;
        logic [31:0] v, ist;
        started = 1;
        if (!rst_n) begin
            m_lctl = 32'h4000_0000; m_rate = 32'h03FF_0000;
            m_lstat = 0; m_ien = 0; m_istat = 0; m_fctl = 0; e_rdata = 0;
            txq.delete(); rxq.delete();
        end else begin
            tc = txq.size(); rc = rxq.size();
            v = 0;
            if (rd_en) begin
                case (waddr)
                    0: v = m_lctl; 1: v = m_lstat; 2: v = m_ien; 3: v = m_istat;
                    4: v = m_fctl; 5: v = m_rate;
                    12: if (be[0] && rc > 0) begin v = {rxq[0], 24'h0}; void'(rxq.pop_front()); end
                    default: v = 0;
                endcase
                v = v & lm(be);
            end
            e_rdata = v;
            ist = m_istat;
            if (wr_en && waddr == 3) ist = m_istat & (wdata | ~lm(be));
            ist[16] = ist[16] | (rc > 0);
            ist[17] = ist[17] | (tc == 0);
            m_istat = ist & 32'h0007_0000;
            if (wr_en && waddr == 0) m_lctl = ld(m_lctl, 32'hE17F_0000);
            if (wr_en && waddr == 2) m_ien  = ld(m_ien,  32'h000F_0000);
            if (wr_en && waddr == 4) m_fctl = ld(m_fctl, 32'h001F_0000);
            if (wr_en && waddr == 5) m_rate = ld(m_rate, 32'h03FF_0000);
            if (tx_ready && tc > 0) void'(txq.pop_front());
            if (wr_en && waddr == 8 && be[0] && tc < 16) txq.push_back(wdata[31:24]);
            if (rx_valid) begin
                if (rc < 16) rxq.push_back(rx_data);
                else m_lstat[16] = 1'b1;
            end
            if (wr_en && waddr == 4 && m_fctl[16]) begin
                if (m_fctl[18]) txq.delete();
                if (m_fctl[17]) rxq.delete();
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("rdata", rdata, e_rdata);
            chk("irq", {31'h0, irq}, {31'h0, |(m_istat & m_ien)});
            chk("tx_valid", {31'h0, tx_valid}, {31'h0, txq.size() > 0});
            if (txq.size() > 0) chk("tx_data", {24'h0, tx_data}, {24'h0, txq[0]});
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 0; rd_en = 0; rx_valid = 0;
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        wr_en = 1; rd_en = 0; rx_valid = 0; waddr = a; wdata = d; be = b;
    endtask

    task automatic rd(input logic [5:0] a, input logic [3:0] b);
        @(negedge clk);
        wr_en = 0; rd_en = 1; rx_valid = 0; waddr = a; be = b;
    endtask

    task automatic rxin(input logic [7:0] d);
        @(negedge clk);
        wr_en = 0; rd_en = 0; rx_valid = 1; rx_data = d;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            miscompares++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1: reset defaults
        cur_req = "R1";
        idle(3);
        @(negedge clk); rst_n = 1;
        for (int a = 0; a < 6; a++) rd(6'(a), 4'hF);
        idle(2);

        // R2: masks, read-only line status, lane-masked reads
        cur_req = "R2";
        wr(0, 32'hFFFF_FFFF, 4'hF); wr(2, 32'hFFFF_FFFF, 4'hF);
        wr(4, 32'h0000_FFFF, 4'hF); wr(5, 32'hFFFF_FFFF, 4'hF);
        wr(1, 32'hFFFF_FFFF, 4'hF);
        for (int a = 0; a < 6; a++) rd(6'(a), 4'hF);
        rd(0, 4'b0001); rd(5, 4'b0010); rd(0, 4'b0000);
        idle(1);

        // R3: partial lane writes
        cur_req = "R3";
        wr(5, 32'h0000_0000, 4'b0010); rd(5, 4'hF);
        wr(5, 32'h0155_0000, 4'b0001); rd(5, 4'hF);
        wr(0, 32'h0000_0000, 4'b0001); rd(0, 4'hF);
        wr(2, 32'h0000_0000, 4'hF); idle(1);

        // R12: unmapped words
        cur_req = "R12";
        wr(6, 32'hFFFF_FFFF, 4'hF); wr(7, 32'hFFFF_FFFF, 4'hF); wr(63, 32'hFFFF_FFFF, 4'hF);
        rd(6, 4'hF); rd(9, 4'hF); rd(16, 4'hF); rd(63, 4'hF);
        for (int a = 0; a < 6; a++) rd(6'(a), 4'hF);

        // R4: transmit pushes, ignored lanes, full drop
        cur_req = "R4";
        tx_ready = 0;
        wr(8, 32'hA5FF_FFFF, 4'b1110);
        rd(8, 4'hF);
        for (int i = 0; i < 18; i++) wr(8, {8'(8'h30 + i), 24'h123456}, 4'b0001);
        idle(2);

        // R5: drain with a stalling ready
        cur_req = "R5";
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            wr_en = 0; rd_en = 0; rx_valid = 0; tx_ready = (i % 3) != 1;
        end
        tx_ready = 0;
        idle(2);

        // R6: receive fill and overrun
        cur_req = "R6";
        rd(1, 4'hF);
        for (int i = 0; i < 18; i++) rxin(8'(8'hC0 + i));
        idle(1);
        rd(1, 4'hF); rd(1, 4'b1101);

        // R7: receive reads
        cur_req = "R7";
        rd(12, 4'b1110);
        for (int i = 0; i < 17; i++) rd(12, (i == 3) ? 4'b0001 : 4'hF);
        rd(12, 4'hF);
        idle(1);

        // R8, R9, R10: flags, clear-only writes, interrupt
        cur_req = "R8";
        rd(3, 4'hF);
        wr(2, 32'h0002_0000, 4'hF); idle(1);
        cur_req = "R9";
        wr(3, 32'h0000_0000, 4'hF); rd(3, 4'hF);
        wr(8, 32'h5500_0000, 4'b0001); idle(1);
        wr(3, 32'h0000_0000, 4'b0010); rd(3, 4'hF);
        wr(3, 32'hFFFF_FFFF, 4'hF); rd(3, 4'hF);
        cur_req = "R10";
        rxin(8'h77); idle(1);
        wr(2, 32'h0001_0000, 4'b0010); idle(1);
        rd(12, 4'b0001); idle(1);
        wr(3, 32'h0000_0000, 4'b0010); idle(1);
        wr(2, 32'h000F_0000, 4'hF); rd(2, 4'hF);
        wr(2, 32'h0000_0000, 4'hF);
        tx_ready = 1; idle(2); tx_ready = 0;

        // R11: flush control
        cur_req = "R11";
        for (int i = 0; i < 5; i++) begin
            wr(8, {8'(8'h60 + i), 24'h0}, 4'b0001);
            rxin(8'(8'h90 + i));
        end
        wr(4, 32'h0006_0000, 4'hF); idle(1);
        rd(4, 4'hF);
        @(negedge clk);
        wr_en = 1; rd_en = 0; waddr = 4; wdata = 32'h0005_0000; be = 4'b0010;
        rx_valid = 1; rx_data = 8'hEE; tx_ready = 1;
        @(negedge clk);
        wr_en = 0; rx_valid = 0; tx_ready = 0;
        idle(1);
        rd(12, 4'hF);
        wr(4, 32'h0000_0000, 4'b0001);
        idle(1);
        wr(4, 32'h0000_0000, 4'b0100); idle(1);
        rd(12, 4'hF); rd(12, 4'hF); idle(1);

        // R1: reset in the middle of traffic
        cur_req = "R1";
        wr(8, 32'h1100_0000, 4'b0001); rxin(8'h22);
        @(negedge clk); rst_n = 0; wr_en = 0; rx_valid = 0;
        idle(1);
        @(negedge clk); rst_n = 1;
        for (int a = 0; a < 6; a++) rd(6'(a), 4'hF);
        rd(12, 4'hF);
        idle(3);
        finish_run();
    end

endmodule